// File: doc/BRIEF.md
# Color Lookup Palette with Host Register Port

This block holds a 256-entry color table. Each entry is 18 bits wide and carries three 6-bit components. The display pipeline sends an 8-bit pixel code every cycle. The block ANDs that code with a programmable pixel mask, looks the result up in the table and returns the registered 18-bit color one cycle later. The output is digital color only; no analog conversion is part of the block.

Software reaches the table through four byte-wide registers selected by a 2-bit offset:

| Offset | Register | Access |
|---|---|---|
| 0 | pixel mask | read and write |
| 1 | read pointer | read and write |
| 2 | write pointer | read and write |
| 3 | component data port | read and write |

The read and write pointers are independent, and each has its own component sequencer. A write through the data port collects red, then green, then blue. The entry is stored only once the blue byte arrives. A read through the data port returns the three components of a snapshot taken when the entry was selected. After the third component, either pointer steps to the next entry on its own, so software can stream a whole table without reloading the pointer.

Top module: `clut_regport`

## Requirements
- R1: After reset the pixel mask reads 8'hFF, both pointers read 0, every table entry is zero, and pix_rgb is zero.
- R2: A write to offset 0 loads the pixel mask, and a read of offset 0 returns it. No other access changes the mask.
- R3: A write to offset 2 loads the write pointer and restarts its sequencer at red. A read of offset 2 returns the write pointer.
- R4: Data-port writes (offset 3) take the low 6 bits of three bytes, in the order red, green, blue. The table entry does not change until the blue byte is written; it then holds all three.
- R5: When the blue byte is written, the write pointer increments by one and wraps from 255 to 0.
- R6: A write to offset 1 loads the read pointer, takes a snapshot of that entry and restarts the read sequencer at red, even in the middle of a sequence. A read of offset 1 returns the read pointer.
- R7: Data-port reads return red, then green, then blue in bits 5:0, with bits 7:6 zero. After blue, the read pointer increments (wrapping 255 to 0) and the snapshot reloads from the new entry.
- R8: One clock after pix_idx is presented, pix_rgb holds the entry at (pix_idx AND mask), packed as red in bits 17:12, green in 11:6 and blue in 5:0.
- R9: If a pixel lookup and a commit target the same entry in the same cycle, the lookup returns the old contents. The next lookup returns the new contents.
- R10: While host_sel is low, host_rdata is zero and the host inputs change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register offset: 0 mask, 1 read pointer, 2 write pointer, 3 data |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the cycle of the read strobe |
| pix_idx | input | 8 | Pixel code from the display pipeline |
| pix_rgb | output | 18 | Looked-up color, one cycle after pix_idx |

## Verification
Host read data is combinational and is due in the same cycle as the read strobe. Its side effects (the sequencer step, the pointer increment and the snapshot reload) take effect at the closing edge. Register writes and table commits are visible from the edge that ends the strobe cycle. A pixel color is due one edge after its code is driven, so a commit shows on the pixel port one edge after the commit edge. The bench drives every input on the falling edge. It samples read data 1 ns after driving the strobe, and it samples pix_rgb on the falling edge after the edge that registers it. That is also how the old-versus-new rule of R9 is checked, across two successive samples.

// File: rtl/clut_pkg.sv
package clut_pkg;
  parameter int IDX_W  = 8;
  parameter int COMP_W = 6;
  parameter int BUS_W  = 8;
  localparam int DEPTH = 1 << IDX_W;
  localparam int RGB_W = 3 * COMP_W;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_RIDX = 2'd1,
    REG_WIDX = 2'd2,
    REG_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    COMP_R = 2'd0,
    COMP_G = 2'd1,
    COMP_B = 2'd2
  } comp_e;

  function automatic logic [RGB_W-1:0] pack_rgb(input logic [COMP_W-1:0] r,
                                                input logic [COMP_W-1:0] g,
                                                input logic [COMP_W-1:0] b);
    return {r, g, b};
  endfunction

  function automatic logic [COMP_W-1:0] pick_comp(input logic [RGB_W-1:0] rgb,
                                                  input comp_e c);
    case (c)
      COMP_R:  return rgb[3*COMP_W-1:2*COMP_W];
      COMP_G:  return rgb[2*COMP_W-1:COMP_W];
      default: return rgb[COMP_W-1:0];
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] mask_idx(input logic [IDX_W-1:0] idx,
                                                input logic [IDX_W-1:0] m);
    return idx & m;
  endfunction

  function automatic comp_e next_comp(input comp_e c);
    case (c)
      COMP_R:  return COMP_G;
      COMP_G:  return COMP_B;
      default: return COMP_R;
    endcase
  endfunction
endpackage

// File: rtl/clut_host_if.sv
module clut_host_if
  import clut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sel,
  input  logic             host_wr,
  input  logic [1:0]       host_addr,
  input  logic [BUS_W-1:0] host_wdata,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [COMP_W-1:0] rd_byte,
  output logic [BUS_W-1:0] host_rdata,
  output logic [IDX_W-1:0] mask,
  output logic             ev_ridx_we,
  output logic             ev_widx_we,
  output logic             ev_data_we,
  output logic             ev_data_re
);
  reg_sel_e sel_reg;
  logic     ev_mask_we;

  assign sel_reg    = reg_sel_e'(host_addr);
  assign ev_mask_we = host_sel &&  host_wr && (sel_reg == REG_MASK);
  assign ev_ridx_we = host_sel &&  host_wr && (sel_reg == REG_RIDX);
  assign ev_widx_we = host_sel &&  host_wr && (sel_reg == REG_WIDX);
  assign ev_data_we = host_sel &&  host_wr && (sel_reg == REG_DATA);
  assign ev_data_re = host_sel && !host_wr && (sel_reg == REG_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n)          mask <= '1;
    else if (ev_mask_we) mask <= host_wdata[IDX_W-1:0];
  end

  always_comb begin
    host_rdata = '0;
    if (host_sel && !host_wr) begin
      case (sel_reg)
        REG_MASK: host_rdata = BUS_W'(mask);
        REG_RIDX: host_rdata = BUS_W'(rd_idx);
        REG_WIDX: host_rdata = BUS_W'(wr_idx);
        default:  host_rdata = BUS_W'(rd_byte);
      endcase
    end
  end
endmodule

// File: rtl/clut_write_seq.sv
module clut_write_seq
  import clut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_widx_we,
  input  logic             ev_data_we,
  input  logic [BUS_W-1:0] host_wdata,
  output logic [IDX_W-1:0] wr_idx,
  output comp_e            wr_comp,
  output logic             commit_en,
  output logic [IDX_W-1:0] commit_addr,
  output logic [RGB_W-1:0] commit_rgb
);
  logic [COMP_W-1:0] red_q, grn_q;

  assign commit_en   = ev_data_we && (wr_comp == COMP_B);
  assign commit_addr = wr_idx;
  assign commit_rgb  = pack_rgb(red_q, grn_q, host_wdata[COMP_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx  <= '0;
      wr_comp <= COMP_R;
      red_q   <= '0;
      grn_q   <= '0;
    end else if (ev_widx_we) begin
      wr_idx  <= host_wdata[IDX_W-1:0];
      wr_comp <= COMP_R;
    end else if (ev_data_we) begin
      wr_comp <= next_comp(wr_comp);
      case (wr_comp)
        COMP_R:  red_q  <= host_wdata[COMP_W-1:0];
        COMP_G:  grn_q  <= host_wdata[COMP_W-1:0];
        default: wr_idx <= wr_idx + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/clut_read_seq.sv
module clut_read_seq
  import clut_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ridx_we,
  input  logic              ev_data_re,
  input  logic [BUS_W-1:0]  host_wdata,
  input  logic [RGB_W-1:0]  preload_rgb,
  output logic [IDX_W-1:0]  preload_addr,
  output logic [IDX_W-1:0]  rd_idx,
  output comp_e             rd_comp,
  output logic [COMP_W-1:0] rd_byte
);
  logic [RGB_W-1:0] snap_q;
  logic             step_entry;
  logic             do_load;

  assign step_entry   = ev_data_re && (rd_comp == COMP_B);
  assign do_load      = ev_ridx_we || step_entry;
  assign preload_addr = ev_ridx_we ? host_wdata[IDX_W-1:0] : rd_idx + 1'b1;
  assign rd_byte      = pick_comp(snap_q, rd_comp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx  <= '0;
      rd_comp <= COMP_R;
      snap_q  <= '0;
    end else begin
      if (do_load) begin
        rd_idx <= preload_addr;
        snap_q <= preload_rgb;
      end
      if (ev_ridx_we)      rd_comp <= COMP_R;
      else if (ev_data_re) rd_comp <= next_comp(rd_comp);
    end
  end
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_en,
  input  logic [IDX_W-1:0] commit_addr,
  input  logic [RGB_W-1:0] commit_rgb,
  input  logic [IDX_W-1:0] preload_addr,
  output logic [RGB_W-1:0] preload_rgb,
  input  logic [IDX_W-1:0] pix_addr,
  output logic [RGB_W-1:0] pix_rgb
);
  logic [RGB_W-1:0] mem [DEPTH];

  assign preload_rgb = mem[preload_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit_en) begin
      mem[commit_addr] <= commit_rgb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_rgb <= '0;
    else        pix_rgb <= mem[pix_addr];
  end
endmodule

// File: rtl/clut_regport.sv
module clut_regport
  import clut_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic [BUS_W-1:0]  host_rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [RGB_W-1:0]  pix_rgb
);
  logic [IDX_W-1:0]  mask_q, rd_idx, wr_idx, preload_addr, commit_addr, pix_addr;
  logic [COMP_W-1:0] rd_byte;
  logic [RGB_W-1:0]  preload_rgb, commit_rgb;
  logic              ev_ridx_we, ev_widx_we, ev_data_we, ev_data_re, commit_en;
  comp_e             rd_comp, wr_comp;

  assign pix_addr = mask_idx(pix_idx, mask_q);

  clut_host_if u_host (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .rd_idx(rd_idx),
    .wr_idx(wr_idx), .rd_byte(rd_byte), .host_rdata(host_rdata),
    .mask(mask_q), .ev_ridx_we(ev_ridx_we), .ev_widx_we(ev_widx_we),
    .ev_data_we(ev_data_we), .ev_data_re(ev_data_re)
  );

  clut_write_seq u_wseq (
    .clk(clk), .rst_n(rst_n), .ev_widx_we(ev_widx_we), .ev_data_we(ev_data_we),
    .host_wdata(host_wdata), .wr_idx(wr_idx), .wr_comp(wr_comp),
    .commit_en(commit_en), .commit_addr(commit_addr), .commit_rgb(commit_rgb)
  );

  clut_read_seq u_rseq (
    .clk(clk), .rst_n(rst_n), .ev_ridx_we(ev_ridx_we), .ev_data_re(ev_data_re),
    .host_wdata(host_wdata), .preload_rgb(preload_rgb),
    .preload_addr(preload_addr), .rd_idx(rd_idx), .rd_comp(rd_comp),
    .rd_byte(rd_byte)
  );

  clut_store u_store (
    .clk(clk), .rst_n(rst_n), .commit_en(commit_en), .commit_addr(commit_addr),
    .commit_rgb(commit_rgb), .preload_addr(preload_addr),
    .preload_rgb(preload_rgb), .pix_addr(pix_addr), .pix_rgb(pix_rgb)
  );
endmodule

// File: rtl/clut_regport_chk.sv
module clut_regport_chk
  import clut_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             host_sel,
  input logic             host_wr,
  input logic [1:0]       host_addr,
  input logic [BUS_W-1:0] host_wdata,
  input logic [IDX_W-1:0] mask_q,
  input logic [IDX_W-1:0] rd_idx,
  input logic [1:0]       rd_comp,
  input logic [IDX_W-1:0] wr_idx,
  input logic [1:0]       wr_comp,
  input logic             ev_ridx_we,
  input logic             ev_widx_we,
  input logic             ev_data_we,
  input logic             ev_data_re,
  input logic             commit_en
);
  logic             mask_wr_port;
  logic [IDX_W-1:0] wr_next, rd_next;
  assign mask_wr_port = host_sel && host_wr && (host_addr == 2'd0);
  assign wr_next      = wr_idx + 1'b1;
  assign rd_next      = rd_idx + 1'b1;

  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_port |=> $stable(mask_q));
  p_widx_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_widx_we |=> (wr_idx == $past(host_wdata[IDX_W-1:0])) && (wr_comp == 2'd0));
  p_comp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data_we && wr_comp == 2'd0) |=> (wr_comp == 2'd1) && $stable(wr_idx));
  p_wptr_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> (wr_idx == $past(wr_next)) && (wr_comp == 2'd0));
  p_ridx_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ridx_we |=> (rd_idx == $past(host_wdata[IDX_W-1:0])) && (rd_comp == 2'd0));
  p_rptr_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data_re && rd_comp == 2'd2) |=> (rd_idx == $past(rd_next)) && (rd_comp == 2'd0));
  p_comp_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_comp != 2'd3) && (rd_comp != 2'd3));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_sel |=> $stable(wr_idx) && $stable(rd_idx) && $stable(wr_comp) && $stable(rd_comp));
  p_events_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ridx_we, ev_widx_we, ev_data_we, ev_data_re}));
endmodule

bind clut_regport clut_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_addr(host_addr), .host_wdata(host_wdata), .mask_q(mask_q),
  .rd_idx(rd_idx), .rd_comp(rd_comp), .wr_idx(wr_idx), .wr_comp(wr_comp),
  .ev_ridx_we(ev_ridx_we), .ev_widx_we(ev_widx_we), .ev_data_we(ev_data_we),
  .ev_data_re(ev_data_re), .commit_en(commit_en)
);

// File: tb/clut_regport_tb.sv
`timescale 1ns/1ps
module clut_regport_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        host_sel = 0, host_wr = 0;
  logic [1:0]  host_addr = 0;
  logic [7:0]  host_wdata = 0;
  logic [7:0]  host_rdata;
  logic [7:0]  pix_idx = 0;
  logic [17:0] pix_rgb;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clut_regport u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 0; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_sel = 0;
  endtask

  task automatic pix(input logic [7:0] i, output logic [17:0] c);
    @(negedge clk);
    pix_idx = i;
    @(negedge clk);
    c = pix_rgb;
  endtask

  function automatic logic [17:0] rgb(input int r, input int g, input int b);
    return {6'(r), 6'(g), 6'(b)};
  endfunction

  task automatic t_reset;
    logic [7:0] d; logic [17:0] c;
    check("R1 pix_rgb after reset", pix_rgb, 0);
    check("R10 idle rdata", host_rdata, 0);
    rd(0, d); check("R1 mask reset", d, 8'hFF);
    rd(1, d); check("R1 read ptr reset", d, 0);
    rd(2, d); check("R1 write ptr reset", d, 0);
    pix(8'd200, c); check("R1 entry 200 zero", c, 0);
  endtask

  task automatic t_write;
    logic [7:0] d; logic [17:0] c;
    wr(2, 8'd5);
    rd(2, d); check("R3 write ptr readback", d, 5);
    wr(3, 8'hD5); wr(3, 8'h2A);
    pix(8'd5, c); check("R4 no commit before blue", c, 0);
    wr(3, 8'hFF);
    pix(8'd5, c); check("R4 R8 entry 5 committed", c, rgb(6'h15, 6'h2A, 6'h3F));
    rd(2, d); check("R5 write ptr incremented", d, 6);
    wr(3, 8'h01); wr(3, 8'h02); wr(3, 8'h03);
    pix(8'd6, c); check("R5 auto-increment to entry 6", c, rgb(1, 2, 3));
    wr(3, 8'h09); wr(2, 8'd9); wr(3, 8'h04); wr(3, 8'h05); wr(3, 8'h06);
    pix(8'd9, c); check("R3 pointer write restarts at red", c, rgb(4, 5, 6));
    pix(8'd7, c); check("R3 aborted sequence left entry 7", c, 0);
  endtask

  task automatic t_wrap;
    logic [7:0] d; logic [17:0] c;
    wr(2, 8'd255);
    wr(3, 8'h11); wr(3, 8'h12); wr(3, 8'h13);
    rd(2, d); check("R5 write ptr wraps", d, 0);
    wr(3, 8'h21); wr(3, 8'h22); wr(3, 8'h23);
    pix(8'd255, c); check("R8 entry 255", c, rgb(6'h11, 6'h12, 6'h13));
    pix(8'd0, c); check("R5 wrapped write to entry 0", c, rgb(6'h21, 6'h22, 6'h23));
  endtask

  task automatic t_read;
    logic [7:0] d;
    wr(1, 8'd5);
    rd(1, d); check("R6 read ptr readback", d, 5);
    rd(3, d); check("R7 red of entry 5", d, 8'h15);
    rd(3, d); check("R7 green of entry 5", d, 8'h2A);
    rd(3, d); check("R7 blue of entry 5", d, 8'h3F);
    rd(1, d); check("R7 read ptr advanced", d, 6);
    rd(3, d); check("R7 red of entry 6 after reload", d, 1);
    wr(1, 8'd255);
    rd(3, d); check("R7 red of entry 255", d, 8'h11);
    wr(1, 8'd255);
    rd(3, d); check("R6 pointer write restarts at red", d, 8'h11);
    rd(3, d); rd(3, d); check("R7 blue of entry 255", d, 8'h13);
    rd(1, d); check("R7 read ptr wraps", d, 0);
    rd(3, d); check("R7 red of entry 0 after wrap", d, 8'h21);
  endtask

  task automatic t_mask;
    logic [7:0] d; logic [17:0] c;
    wr(0, 8'h0F);
    rd(0, d); check("R2 mask readback", d, 8'h0F);
    pix(8'hF5, c); check("R8 masked index F5 -> 5", c, rgb(6'h15, 6'h2A, 6'h3F));
    pix(8'h36, c); check("R8 masked index 36 -> 6", c, rgb(1, 2, 3));
    wr(0, 8'h00);
    pix(8'hFF, c); check("R8 zero mask -> entry 0", c, rgb(6'h21, 6'h22, 6'h23));
    wr(0, 8'hFF);
    rd(0, d); check("R2 mask restored", d, 8'hFF);
  endtask

  task automatic t_idle;
    logic [7:0] d;
    @(negedge clk);
    host_sel = 0; host_wr = 1; host_addr = 0; host_wdata = 8'h00;
    #1 check("R10 rdata zero without strobe", host_rdata, 0);
    @(negedge clk);
    host_addr = 2; host_wdata = 8'h77;
    @(negedge clk);
    host_wr = 0;
    rd(0, d); check("R10 mask untouched", d, 8'hFF);
    rd(2, d); check("R10 write ptr untouched", d, 1);
  endtask

  task automatic t_collide;
    logic [17:0] c;
    wr(2, 8'd7);
    wr(3, 8'h31); wr(3, 8'h32);
    @(negedge clk); pix_idx = 8'd7;
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = 3; host_wdata = 8'h33;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
    c = pix_rgb; check("R9 same-cycle lookup sees old", c, 0);
    @(negedge clk);
    c = pix_rgb; check("R9 next lookup sees new", c, rgb(6'h31, 6'h32, 6'h33));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_wrap();
    t_read();
    t_mask();
    t_idle();
    t_collide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule